// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block watches eight external interrupt pins and turns activity on them into one interrupt request per pin. Each pin has a two-bit sense code. The code selects one of three conditions: the pin held low, a falling edge, or a rising edge. An edge is latched in a per-pin pending flag. A held-low condition is not latched; it requests directly for as long as the pin stays low. A request reaches its output only when the pin's mask bit and the global enable input are both set. The pins are sensed whatever drives them, so software can raise an interrupt by driving a pin it owns as an output.

The four low pins catch edges with flops clocked by the pin itself. A two-flop synchroniser then brings each captured edge into the system clock domain. These pins keep catching edges, even pulses shorter than a clock period, while the I/O clock is stopped. The four high pins compare synchronised samples and recognise an edge only while the I/O clock runs, which `io_clk_on` reports. A change of a pin's edge polarity moves its internal comparison point. If the pin already sits at the new active level, that change records an event, and the block reproduces this on purpose.

Software reaches four byte-wide registers through a simple write strobe and a combinational read port. Pending flags are cleared by writing ones to them or by the per-pin acknowledge input.

Top module: `xpin_irq_sense`

## Requirements
- R1: After reset, both sense registers, the mask and the flags read 0, every pin is in low-level mode, and `irq_req` is 0.
- R2: The `reg_addr` map is as follows. Address 0 holds the sense codes of pins 3..0, with pin n at bits 2n+1:2n. Address 1 holds pins 7..4, with pin n at bits 2(n-4)+1:2(n-4). Address 2 is the mask, address 3 is the flags, and `reg_rdata` returns the addressed register in the same cycle.
- R3: `irq_req[n]` is 1 only while `gie` and mask bit n are both 1. A flag that is set while it is masked or while `gie` is 0 remains pending.
- R4: Sense code 00 selects the low level. If pin n goes low before clock edge k, then `irq_req[n]` follows from edge k+1 for as long as the pin stays low. No flag is set in this mode.
- R5: Code 10 selects the falling edge and code 11 the rising edge. A matching transition between edges k-1 and k sets flag n at edge k+2, whatever the mask holds.
- R6: A flag is cleared by a write of 1 to its bit at address 3 or by `irq_ack[n]`. Bits written as 0 leave their flags unchanged.
- R7: When a new edge event and a clear reach the same flag at the same edge, the flag ends up set.
- R8: Pins 3..0 record an edge even when both transitions of a pulse fall between two clock edges, and even while `io_clk_on` is 0.
- R9: Pins 7..4 recognise an edge only if `io_clk_on` is 1 in the cycle before the setting edge. Transitions made while it is 0, and pulses shorter than a clock period, are lost.
- R10: Suppose a sense write changes pin n's edge polarity (11 versus any other code) to an edge mode. If the synchronised pin already sits at the new active level (high for 11, low for 10), flag n is set one edge after the write takes effect.
- R11: Code 01 is reserved: it never raises `irq_req[n]` and never sets flag n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for registers and synchronisers |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_clk_on | input | 1 | High while the I/O clock runs; gates edge detection on pins 7..4 |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | 8 | External pin levels, sensed regardless of pin direction |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_ack | input | 8 | Per-pin acknowledge; clears the flag |
| irq_req | output | 8 | Per-pin interrupt request |

## Verification
Two actions can meet on one flag at the same clock edge: a new edge event sets it, and a write-one or an acknowledge clears it. The bench sets up this collision on purpose. It raises a pin in rising mode and then, counting the three register stages to the setting edge, pulses `irq_ack` so that the acknowledge lands on exactly that edge. A behavioural model in the bench computes the next value of every flag from set, clear and hold terms. It compares every request and readback on every cycle, and a final readback confirms that the flag stays pending.

// File: rtl/xpin_irq_sense.sv
`timescale 1ns/1ps
module xpin_irq_sense #(
  parameter int ASYNC_PINS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_clk_on,
  input  logic       gie,
  input  logic [7:0] pin_in,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] irq_ack,
  output logic [7:0] irq_req
);
  localparam int NP = 8;
  localparam int SW = 2 * NP;

  logic [SW-1:0] sense_q;
  logic [NP-1:0] mask_q, flag_q, pol_q, lv1, lv2;
  logic [NP-1:0] set_v, src_v, wclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
      lv1     <= '1;
      lv2     <= '1;
    end else begin
      lv1 <= pin_in;
      lv2 <= lv1;
      if (reg_we && reg_addr == 2'd0) sense_q[7:0]  <= reg_wdata;
      if (reg_we && reg_addr == 2'd1) sense_q[15:8] <= reg_wdata;
      if (reg_we && reg_addr == 2'd2) mask_q        <= reg_wdata;
    end
  end

  assign wclr = (reg_we && reg_addr == 2'd3) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pol_q  <= '0;
    end else begin
      flag_q <= set_v | (flag_q & ~wclr & ~irq_ack);
      for (int i = 0; i < NP; i++) pol_q[i] <= (sense_q[2*i +: 2] == 2'b11);
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    logic [1:0] code;
    logic edge_m, rise_m, re, fe, spur;
    assign code   = sense_q[2*i +: 2];
    assign edge_m = code[1];
    assign rise_m = (code == 2'b11);

    if (i < ASYNC_PINS) begin : g_async
      logic tr, tf;
      logic [2:0] sr, sf;
      always_ff @(posedge pin_in[i] or negedge rst_n)
        if (!rst_n) tr <= 1'b0; else tr <= ~tr;
      always_ff @(negedge pin_in[i] or negedge rst_n)
        if (!rst_n) tf <= 1'b0; else tf <= ~tf;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
          sf <= '0;
        end else begin
          sr <= {sr[1:0], tr};
          sf <= {sf[1:0], tf};
        end
      end
      assign re = sr[2] ^ sr[1];
      assign fe = sf[2] ^ sf[1];
    end else begin : g_sync
      logic hp;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hp <= 1'b1; else hp <= lv2[i];
      assign re = io_clk_on & lv2[i] & ~hp;
      assign fe = io_clk_on & ~lv2[i] & hp;

      AST_UPPER_NEEDS_IOCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_clk_on && !spur) |=> !$rose(flag_q[i])); // R9
    end

    assign spur     = edge_m & (rise_m != pol_q[i]) & (rise_m ? lv2[i] : ~lv2[i]);
    assign set_v[i] = edge_m & ((rise_m ? re : fe) | spur);
    assign src_v[i] = edge_m ? flag_q[i] : (code == 2'b00) & ~lv2[i];

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b00) |=> !$rose(flag_q[i])); // R4
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b01) |=> !$rose(flag_q[i])); // R11
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flag_q[i]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !set_v[i]) |=> !flag_q[i]); // R6
  end

  assign irq_req = {NP{gie}} & mask_q & src_v;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sense_q[7:0];
      2'd1:    reg_rdata = sense_q[15:8];
      2'd2:    reg_rdata = mask_q;
      default: reg_rdata = flag_q;
    endcase
  end

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~mask_q) == '0); // R3
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0)); // R3
endmodule

// File: tb/sim_xpin_irq_sense.sv
`timescale 1ns/1ps
module sim_xpin_irq_sense;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_clk_on = 1'b1;
  logic gie = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] irq_ack = 8'h00;
  logic [7:0] reg_rdata, irq_req;

  always #2.5 clk = ~clk;

  xpin_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .io_clk_on(io_clk_on), .gie(gie),
    .pin_in(pins), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  logic [15:0] m_sense, m_prev;
  logic [7:0] m_mask, m_flag;
  logic [7:0] ps1, ps2, ps3, wr1, wr2, wf1, wf2;
  logic [7:0] pr = 8'h00, pf = 8'h00, lastp = 8'hFF;

  always @(pins) begin
    for (int i = 0; i < 8; i++) begin
      if (pins[i] && !lastp[i]) pr[i] = 1'b1;
      if (!pins[i] && lastp[i]) pf[i] = 1'b1;
    end
    lastp = pins;
  end

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] c;
      c = m_sense[2*i +: 2];
      r[i] = gie & m_mask[i] & (c[1] ? m_flag[i] : (c == 2'b00) & ~ps2[i]);
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd();
    case (reg_addr)
      2'd0: return m_sense[7:0];
      2'd1: return m_sense[15:8];
      2'd2: return m_mask;
      default: return m_flag;
    endcase
  endfunction

  task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sense = '0; m_prev = '0; m_mask = '0; m_flag = '0;
      ps1 = '1; ps2 = '1; ps3 = '1;
      wr1 = '0; wr2 = '0; wf1 = '0; wf2 = '0;
      pr = '0; pf = '0;
    end else begin
      logic [7:0] nf;
      for (int i = 0; i < 8; i++) begin
        logic [1:0] c, pc;
        logic rm, re, fe, spur, setb, clr;
        c = m_sense[2*i +: 2];
        pc = m_prev[2*i +: 2];
        rm = (c == 2'b11);
        if (i < 4) begin
          re = wr2[i]; fe = wf2[i];
        end else begin
          re = io_clk_on & ps2[i] & ~ps3[i];
          fe = io_clk_on & ~ps2[i] & ps3[i];
        end
        spur = c[1] && (rm != (pc == 2'b11)) && (rm ? ps2[i] : !ps2[i]);
        setb = c[1] && ((rm ? re : fe) || spur);
        clr = irq_ack[i] || (reg_we && reg_addr == 2'd3 && reg_wdata[i]);
        nf[i] = setb || (m_flag[i] && !clr);
      end
      m_prev = m_sense;
      m_flag = nf;
      if (reg_we && reg_addr == 2'd0) m_sense[7:0] = reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_sense[15:8] = reg_wdata;
      if (reg_we && reg_addr == 2'd2) m_mask = reg_wdata;
      ps3 = ps2; ps2 = ps1; ps1 = pins;
      wr2 = wr1; wr1 = pr; wf2 = wf1; wf1 = pf;
      pr = '0; pf = '0;
    end
    #1;
    if (rst_n && !finished) begin
      check8(cur_req, "irq_req vs model", irq_req, exp_irq());
      check8(cur_req, "reg_rdata vs model", reg_rdata, exp_rd());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [1:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1.2;
    check8(tag, "readback", reg_rdata, e);
  endtask

  task automatic expect_irq(input string tag, input logic [7:0] e);
    @(posedge clk);
    #1.2;
    check8(tag, "irq_req", irq_req, e);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pins[n] = v;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R1";
    expect_irq("R1", 8'h00);
    expect_rd("R1", 2'd0, 8'h00);
    expect_rd("R1", 2'd1, 8'h00);
    expect_rd("R1", 2'd2, 8'h00);
    expect_rd("R1", 2'd3, 8'h00);

    cur_req = "R3";
    wr(2'd2, 8'hFF);
    expect_rd("R2", 2'd2, 8'hFF);
    set_pin(2, 1'b0);
    idle(3);
    expect_irq("R3", 8'h00);
    cur_req = "R4";
    gie = 1'b1;
    idle(2);
    expect_irq("R4", 8'h04);
    expect_rd("R4", 2'd3, 8'h00);
    set_pin(2, 1'b1);
    idle(3);
    expect_irq("R4", 8'h00);

    cur_req = "R5";
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'hAA);
    expect_rd("R2", 2'd0, 8'hAA);
    expect_rd("R2", 2'd1, 8'hAA);
    set_pin(1, 1'b0);
    idle(4);
    expect_rd("R5", 2'd3, 8'h02);
    expect_irq("R5", 8'h02);
    set_pin(5, 1'b0);
    idle(4);
    expect_rd("R5", 2'd3, 8'h22);
    cur_req = "R6";
    wr(2'd3, 8'h00);
    expect_rd("R6", 2'd3, 8'h22);
    wr(2'd3, 8'h02);
    expect_rd("R6", 2'd3, 8'h20);
    @(negedge clk); irq_ack = 8'h20;
    @(negedge clk); irq_ack = 8'h00;
    expect_rd("R6", 2'd3, 8'h00);
    set_pin(1, 1'b1);
    set_pin(5, 1'b1);
    idle(4);
    expect_rd("R5", 2'd3, 8'h00);

    cur_req = "R10";
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    idle(2);
    expect_rd("R10", 2'd3, 8'hFF);
    wr(2'd3, 8'hFF);
    expect_rd("R10", 2'd3, 8'h00);

    cur_req = "R7";
    set_pin(2, 1'b0);
    idle(4);
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); irq_ack = 8'h04;
    @(negedge clk); irq_ack = 8'h00;
    expect_rd("R7", 2'd3, 8'h04);
    @(negedge clk); irq_ack = 8'h04;
    @(negedge clk); irq_ack = 8'h00;
    expect_rd("R6", 2'd3, 8'h00);

    cur_req = "R8";
    set_pin(0, 1'b0);
    set_pin(6, 1'b0);
    idle(4);
    expect_rd("R8", 2'd3, 8'h00);
    @(negedge clk); #0.5 pins[0] = 1'b1; #0.5 pins[0] = 1'b0;
    idle(4);
    expect_rd("R8", 2'd3, 8'h01);
    wr(2'd3, 8'h01);
    cur_req = "R9";
    @(negedge clk); #0.5 pins[6] = 1'b1; #0.5 pins[6] = 1'b0;
    idle(4);
    expect_rd("R9", 2'd3, 8'h00);
    set_pin(0, 1'b1);
    set_pin(6, 1'b1);
    idle(4);
    wr(2'd3, 8'hFF);

    set_pin(3, 1'b0);
    set_pin(4, 1'b0);
    idle(4);
    @(negedge clk); io_clk_on = 1'b0;
    set_pin(3, 1'b1);
    set_pin(4, 1'b1);
    idle(5);
    @(negedge clk); io_clk_on = 1'b1;
    idle(4);
    expect_rd("R8", 2'd3, 8'h08);
    expect_rd("R9", 2'd3, 8'h08);
    wr(2'd3, 8'hFF);

    cur_req = "R11";
    wr(2'd1, 8'h7F);
    set_pin(7, 1'b0);
    idle(4);
    expect_irq("R11", 8'h00);
    expect_rd("R11", 2'd3, 8'h00);
    set_pin(7, 1'b1);
    idle(4);
    expect_rd("R11", 2'd3, 8'h00);

    cur_req = "R3";
    wr(2'd2, 8'hFE);
    set_pin(0, 1'b0);
    idle(3);
    set_pin(0, 1'b1);
    idle(4);
    expect_rd("R5", 2'd3, 8'h01);
    expect_irq("R3", 8'h00);
    @(negedge clk); gie = 1'b0;
    wr(2'd2, 8'hFF);
    expect_irq("R3", 8'h00);
    @(negedge clk); gie = 1'b1;
    expect_irq("R3", 8'h01);
    idle(3);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule